// File: doc/BRIEF.md
# Shared Interrupt Node Request Logic

This block gathers a set of peripheral event flags that share one interrupt node and turns them into a single pending-request line for a CPU. Each event owns a status flag, set by a one-cycle pulse from its peripheral and cleared by a software strobe. An event may also have its own enable bit. Whether it has one is fixed per flag by a parameter. Events without their own enable are gated only by the node enable.

The node request is the OR of all flags. A pending request is latched only on a rising edge of that OR. While any flag stays set, later events on other flags produce no new edge and are not seen until every flag has been cleared. The pending latch is cleared by the CPU acknowledge. It is also cleared by hardware whenever no qualified flag remains. A flag is qualified when it is set, the node is enabled, and its own enable (if it has one) is high. The pending output is the latch gated by the node enable.

The reset `rst_n` is active low and asserts asynchronously. It is expected to be released synchronously to `clk` by the reset tree that feeds it.

Top module: `intn_node`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `flags_o` is all zero and `irq_o` is low.
- R2: A high bit of `evt_set_i` sets the matching bit of `flags_o` at the next clock edge, and the flag stays set until it is cleared.
- R3: A high bit of `flag_clr_i` clears the matching flag at the next edge, unless the set pulse for that flag is high in the same cycle, in which case the flag ends set. A clear one cycle after a set removes the flag.
- R4: The pending latch sets when the OR of all flags goes from 0 to 1 and at least one flag is qualified in that cycle. With the node enabled, a set pulse on an idle, enabled event raises `irq_o` two edges after the pulse.
- R5: While any flag remains set, a new event on another flag creates no new pending request. Once all flags have been cleared, the next event raises one again.
- R6: `cpu_ack_i` clears the pending latch at the next edge, unless a rising edge of the flag OR occurs in the same cycle.
- R7: When no flag is qualified in a cycle, the pending latch is cleared at the next edge, whether or not an acknowledge is given.
- R8: A flag whose own enable is low is not qualified. It neither creates a pending request nor keeps one alive.
- R9: A flag marked by `OWN_EN_MASK` as having no own enable is qualified whenever it is set and `node_en_i` is high, whatever the value of its `evt_en_i` bit.
- R10: `irq_o` equals the pending latch ANDed with `node_en_i` in the same cycle. Dropping `node_en_i` unqualifies every flag, so a pending request is gone when the node is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| evt_set_i | input | N_EVT | Per-event set pulses from the peripherals |
| flag_clr_i | input | N_EVT | Per-event software clear strobes |
| evt_en_i | input | N_EVT | Per-event interrupt enables (ignored for flags without own enable) |
| node_en_i | input | 1 | Node interrupt enable |
| cpu_ack_i | input | 1 | CPU acknowledge/vector strobe for this node |
| flags_o | output | N_EVT | Current event status flags |
| irq_o | output | 1 | Pending request to the CPU |

## Verification
The bench builds the node with five events and `OWN_EN_MASK = 5'b01101`. Flags 1 and 4 therefore have no own enable, and the other three do. With this mix, one run can mix qualified and unqualified flags in the same cycle, and can show a flag without its own enable holding a request while every `evt_en_i` bit is low. The directed cases cover edge loss while a flag stays set, same-cycle set/clear, and acknowledge against hardware clearing. A long pseudo-random phase then keeps these in play against the per-cycle model.

// File: rtl/intn_pkg.sv
package intn_pkg;

  // Action taken on the pending latch in a given cycle.
  typedef enum logic [1:0] {
    PEND_HOLD = 2'd0,
    PEND_SET  = 2'd1,
    PEND_DROP = 2'd2
  } pend_act_e;

  // Default node width and per-flag own-enable marking.
  localparam int unsigned DEF_N_EVT = 4;

endpackage

// File: rtl/intn_flag_bank.sv
module intn_flag_bank #(
  parameter int unsigned N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] set_i,
  input  logic [N_EVT-1:0] clr_i,
  output logic [N_EVT-1:0] flags_q,
  output logic             flags_or
);

  logic [N_EVT-1:0] flag_d;
  logic [N_EVT-1:0] flag_ce;

  for (genvar g = 0; g < N_EVT; g++) begin : g_flag
    // Next state: a set pulse wins over a clear strobe in the same cycle.
    always_comb begin
      flag_ce[g] = set_i[g] | clr_i[g];
      flag_d[g]  = set_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[g] <= 1'b0;
      end else if (flag_ce[g]) begin
        flags_q[g] <= flag_d[g];
      end
    end
  end

  assign flags_or = |flags_q;

endmodule

// File: rtl/intn_qualify.sv
module intn_qualify #(
  parameter int unsigned          N_EVT       = 4,
  parameter logic [N_EVT-1:0]     OWN_EN_MASK = '1
) (
  input  logic [N_EVT-1:0] flags_i,
  input  logic [N_EVT-1:0] evt_en_i,
  input  logic             node_en_i,
  output logic             any_qual_o
);

  logic [N_EVT-1:0] qual;

  for (genvar g = 0; g < N_EVT; g++) begin : g_qual
    if (OWN_EN_MASK[g]) begin : g_own
      // Event has its own enable: needs node and event enable.
      assign qual[g] = flags_i[g] & evt_en_i[g] & node_en_i;
    end else begin : g_node
      // Event gated only by the node enable.
      assign qual[g] = flags_i[g] & node_en_i;
    end
  end

  assign any_qual_o = |qual;

endmodule

// File: rtl/intn_pend_latch.sv
module intn_pend_latch
  import intn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_or_i,
  input  logic any_qual_i,
  input  logic ack_i,
  output logic pend_q
);

  logic      prev_or_q;
  logic      rise;
  pend_act_e act;
  logic      pend_d;
  logic      pend_ce;

  assign rise = req_or_i & ~prev_or_q;

  // Next-state: loss of all qualified flags dominates; a fresh edge beats ack.
  always_comb begin
    act = PEND_HOLD;
    if (!any_qual_i) begin
      act = PEND_DROP;
    end else if (rise) begin
      act = PEND_SET;
    end else if (ack_i) begin
      act = PEND_DROP;
    end
  end

  always_comb begin
    pend_ce = (act != PEND_HOLD);
    pend_d  = (act == PEND_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_or_q <= 1'b0;
    end else begin
      prev_or_q <= req_or_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/intn_node.sv
module intn_node #(
  parameter int unsigned      N_EVT       = intn_pkg::DEF_N_EVT,
  parameter logic [N_EVT-1:0] OWN_EN_MASK = {1'b0, {(N_EVT-1){1'b1}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_set_i,
  input  logic [N_EVT-1:0] flag_clr_i,
  input  logic [N_EVT-1:0] evt_en_i,
  input  logic             node_en_i,
  input  logic             cpu_ack_i,
  output logic [N_EVT-1:0] flags_o,
  output logic             irq_o
);

  logic [N_EVT-1:0] flags_q;
  logic             flags_or;
  logic             any_qual;
  logic             pend_q;

  intn_flag_bank #(
    .N_EVT (N_EVT)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_set_i),
    .clr_i    (flag_clr_i),
    .flags_q  (flags_q),
    .flags_or (flags_or)
  );

  intn_qualify #(
    .N_EVT       (N_EVT),
    .OWN_EN_MASK (OWN_EN_MASK)
  ) u_qual (
    .flags_i    (flags_q),
    .evt_en_i   (evt_en_i),
    .node_en_i  (node_en_i),
    .any_qual_o (any_qual)
  );

  intn_pend_latch u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_or_i   (flags_or),
    .any_qual_i (any_qual),
    .ack_i      (cpu_ack_i),
    .pend_q     (pend_q)
  );

  assign flags_o = flags_q;
  assign irq_o   = pend_q & node_en_i;

endmodule

// File: rtl/intn_node_chk.sv
module intn_node_chk #(
  parameter int unsigned      N_EVT       = 4,
  parameter logic [N_EVT-1:0] OWN_EN_MASK = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_set_i,
  input logic [N_EVT-1:0] flag_clr_i,
  input logic [N_EVT-1:0] evt_en_i,
  input logic             node_en_i,
  input logic             cpu_ack_i,
  input logic [N_EVT-1:0] flags_o,
  input logic             irq_o
);

  logic qual_now;
  assign qual_now = node_en_i & (|(flags_o & (evt_en_i | ~OWN_EN_MASK)));

  for (genvar g = 0; g < N_EVT; g++) begin : g_flag_chk
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set_i[g] |=> flags_o[g]); // R2
    AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i[g] && !evt_set_i[g]) |=> !flags_o[g]); // R3
  end

  AST_NEW_REQ_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (node_en_i && $past(node_en_i) && !$past(irq_o) && irq_o)
      |-> ($past(|flags_o) && !$past(|flags_o, 2))); // R4

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack_i && $past(|flags_o)) |=> !irq_o); // R6

  AST_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(qual_now)); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !node_en_i |-> !irq_o); // R10

endmodule

bind intn_node intn_node_chk #(
  .N_EVT       (N_EVT),
  .OWN_EN_MASK (OWN_EN_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_set_i  (evt_set_i),
  .flag_clr_i (flag_clr_i),
  .evt_en_i   (evt_en_i),
  .node_en_i  (node_en_i),
  .cpu_ack_i  (cpu_ack_i),
  .flags_o    (flags_o),
  .irq_o      (irq_o)
);

// File: tb/tb_intn_node.sv
`timescale 1ns/1ps
module tb_intn_node;

  localparam int unsigned      N   = 5;
  localparam logic [N-1:0]     OWN = 5'b01101;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] evt_set;
  logic [N-1:0] flag_clr;
  logic [N-1:0] evt_en;
  logic         node_en;
  logic         ack;
  logic [N-1:0] flags;
  logic         irq;

  intn_node #(.N_EVT(N), .OWN_EN_MASK(OWN)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_set_i  (evt_set),
    .flag_clr_i (flag_clr),
    .evt_en_i   (evt_en),
    .node_en_i  (node_en),
    .cpu_ack_i  (ack),
    .flags_o    (flags),
    .irq_o      (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag   = "R1";
  bit    done  = 0;

  // Behavioural reference model, advanced on each rising edge.
  logic [N-1:0] m_flags;
  logic         m_prev;
  logic         m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = '0;
      m_prev  = 1'b0;
      m_pend  = 1'b0;
    end else begin
      bit anyq;
      bit cur;
      anyq = 0;
      for (int i = 0; i < N; i++)
        if (m_flags[i] && node_en && (!OWN[i] || evt_en[i])) anyq = 1;
      cur = (m_flags != '0);
      if (!anyq)              m_pend = 1'b0;
      else if (cur && !m_prev) m_pend = 1'b1;
      else if (ack)           m_pend = 1'b0;
      m_prev = cur;
      for (int i = 0; i < N; i++) begin
        if (evt_set[i])       m_flags[i] = 1'b1;
        else if (flag_clr[i]) m_flags[i] = 1'b0;
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (flags !== m_flags || irq !== (m_pend & node_en)) begin
        n_bad++;
        $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b",
                 tag, flags, irq, m_flags, m_pend & node_en);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_set(input logic [N-1:0] m);
    evt_set = m; tick(); evt_set = '0;
  endtask

  task automatic pulse_clr(input logic [N-1:0] m);
    flag_clr = m; tick(); flag_clr = '0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  // Directed check with an explicitly worked-out expected value.
  task automatic expect_irq(input logic exp, input string req);
    @(negedge clk);
    #0.5;
    n_cmp++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%b expected %b", req, irq, exp);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_set = '0; flag_clr = '0; evt_en = '1;
    node_en = 1'b1; ack = 1'b0;
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_irq(1'b0, "R1");

    // R2/R4: set pulse then pending two edges later.
    tag = "R4";
    evt_set = 5'b00001; tick(); evt_set = '0;
    tick();
    expect_irq(1'b1, "R4");
    // R6: acknowledge drops the pending request.
    tag = "R6";
    pulse_ack();
    expect_irq(1'b0, "R6");

    // R5: flag 0 still set, new event on flag 2 is not seen.
    tag = "R5";
    pulse_set(5'b00100);
    tick();
    expect_irq(1'b0, "R5");
    pulse_clr(5'b00101);
    tick();
    pulse_set(5'b00100);
    tick();
    expect_irq(1'b1, "R5");

    // R7: clearing all qualified flags drops pending without ack.
    tag = "R7";
    pulse_clr(5'b00100);
    tick();
    expect_irq(1'b0, "R7");

    // R3: same-cycle set and clear keeps the flag; clear a cycle later removes it.
    tag = "R3";
    evt_set = 5'b00010; flag_clr = 5'b00010; tick();
    evt_set = '0; flag_clr = '0;
    tick();
    pulse_clr(5'b00010);
    repeat (2) tick();
    pulse_set(5'b01000);
    pulse_clr(5'b01000);
    repeat (2) tick();

    // R8: disabled event neither raises nor holds pending.
    tag = "R8";
    evt_en = 5'b11110;
    pulse_set(5'b00001);
    tick();
    expect_irq(1'b0, "R8");
    pulse_clr(5'b00001);
    pulse_set(5'b00100);
    tick();
    expect_irq(1'b1, "R8");
    pulse_set(5'b00001);
    evt_en = 5'b11010;
    tick();
    expect_irq(1'b0, "R8");
    pulse_clr(5'b00101);
    tick();

    // R9: flag without own enable works with all event enables low.
    tag = "R9";
    evt_en = '0;
    pulse_set(5'b00010);
    tick();
    expect_irq(1'b1, "R9");

    // R10: node disable gates output and kills the pending request.
    tag = "R10";
    node_en = 1'b0;
    expect_irq(1'b0, "R10");
    node_en = 1'b1;
    tick();
    expect_irq(1'b0, "R10");
    pulse_clr(5'b00010);
    evt_en = '1;
    tick();

    // Mixed pseudo-random traffic against the model.
    tag = "R7";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      evt_set  = (r < 25) ? N'($urandom) & N'($urandom) : '0;
      flag_clr = (r > 70) ? N'($urandom) : '0;
      ack      = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 49) == 0) evt_en = N'($urandom);
      node_en  = ($urandom_range(0, 29) != 0);
      tick();
    end
    evt_set = '0; flag_clr = '0; ack = 1'b0;
    repeat (3) tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule